// File: doc/BRIEF.md
# Transceiver Recalibration Sequencer

This block drives a transceiver's reconfiguration port as a memory-mapped bus master and walks through the fixed set of register accesses that starts an analog recalibration. A one-cycle start pulse latches the calibration choices. The block then asks for ownership of the internal configuration bus and polls the capability register until ownership is granted. It writes the calibration enable register with adaptation triggering forced off. It updates the rate-switch flag and the busy-output enables by read-modify-write, so neighbouring bits keep their values. Finally it hands the bus back to the on-chip calibration engine and polls the busy bits until calibration has finished.

Each bus access holds its strobe, address and write data while `bus_wait_i` is high. A read's data is taken when `bus_rvalid_i` arrives. A programmable cycle limit bounds the two polling phases. When the limit is reached, the block raises an error flag and goes back to idle. A successful run ends with a one-cycle done pulse.

States: `ST_IDLE`, `ST_REQ` (ownership request write), `ST_GRANT_RD` (grant poll read), `ST_CALEN` (enable write), `ST_RATE_RD`/`ST_RATE_WR` (rate flag read-modify-write), `ST_CAP_RD`/`ST_CAP_WR` (busy-output enable read-modify-write), `ST_REL` (release write), `ST_POLL_RD` (completion poll read), `ST_DONE`. Transitions:
- IDLE→REQ on start.
- Each access state moves to the next state on access completion.
- GRANT_RD→CALEN when the grant bit reads 0. GRANT_RD→GRANT_RD otherwise. GRANT_RD→IDLE on timeout.
- POLL_RD→DONE when both busy bits read 0. POLL_RD→POLL_RD otherwise. POLL_RD→IDLE on timeout.
- DONE→IDLE.

Top module: `xcvr_recal_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `err_o` are low and no read or write strobe is driven.
- R2: A bus access never asserts read and write together. While `bus_wait_i` is high it keeps its strobe, address and write data unchanged.
- R3: The first access after an accepted start writes data 0x2 to address 0x000.
- R4: The block then reads address 0x281 repeatedly and makes no other access until bit 2 of the read data is 0.
- R5: The next access writes address 0x100. Bit 1 is the RX calibration enable, bit 5 is the TX calibration enable, and every other bit is 0, including bit 6.
- R6: Address 0x166 is read, then written back with bit 7 equal to `rate_kept_i` (1 means no rate switch) and all other bits as read.
- R7: Address 0x281 is read, then written back with bit 5 equal to `rx_busy_oe_i` and bit 4 equal to `tx_busy_oe_i`, all other bits as read.
- R8: The next access writes data 0x1 to address 0x000, returning the bus to the calibration engine.
- R9: Address 0x281 is then polled until bit 1 (RX busy) and bit 0 (TX busy) both read 0. Then `done_o` pulses for exactly one cycle and `busy_o` drops with no further access.
- R10: A start pulse while `busy_o` is high has no effect. The running sequence, its latched settings and its single done pulse are unchanged.
- R11: If either poll phase has lasted `tmo_limit_i` cycles when a read still shows not ready, the block sets `err_o`, returns to idle and makes no more accesses. The next accepted start clears `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle start request |
| tx_cal_en_i | input | 1 | Select TX calibration group |
| rx_cal_en_i | input | 1 | Select RX calibration group |
| rate_kept_i | input | 1 | 1: no rate switch; 0: rate changed with a new CDR bandwidth |
| tx_busy_oe_i | input | 1 | Enable the TX busy output of the transceiver |
| rx_busy_oe_i | input | 1 | Enable the RX busy output of the transceiver |
| tmo_limit_i | input | TOW | Cycle limit for each polling phase |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout flag, held until the next start |
| bus_addr_o | output | 10 | Register address |
| bus_wr_o | output | 1 | Write strobe |
| bus_rd_o | output | 1 | Read strobe |
| bus_wdata_o | output | DW | Write data |
| bus_wait_i | input | 1 | Slave stall; the access is held while high |
| bus_rdata_i | input | DW | Read data |
| bus_rvalid_i | input | 1 | Read data valid |

## Verification
A wrong state register shows at the bus within one access. The scoreboard compares every write, in order, against the address and data the requirements predict. A write that arrives early, late or with damaged bits is therefore flagged on the cycle it is accepted. Leaving a poll phase too early shows as a write while the model's grant bit is still set, or as a done pulse while its busy bits are set. A stuck state shows as `busy_o` never falling, or as an error flag where a done pulse was due.

// File: rtl/recal_seq_pkg.sv
package recal_seq_pkg;

    localparam int unsigned RC_AW = 10;

    localparam logic [RC_AW-1:0] RC_ADDR_ARB   = 10'h000;
    localparam logic [RC_AW-1:0] RC_ADDR_CALEN = 10'h100;
    localparam logic [RC_AW-1:0] RC_ADDR_RATE  = 10'h166;
    localparam logic [RC_AW-1:0] RC_ADDR_CAP   = 10'h281;

    localparam int unsigned RC_ARB_REQ = 2;
    localparam int unsigned RC_ARB_REL = 1;

    // bit positions
    localparam int unsigned RC_BIT_GRANT_PEND = 2;
    localparam int unsigned RC_BIT_RXBUSY     = 1;
    localparam int unsigned RC_BIT_TXBUSY     = 0;
    localparam int unsigned RC_BIT_RXBOE      = 5;
    localparam int unsigned RC_BIT_TXBOE      = 4;
    localparam int unsigned RC_BIT_RATE       = 7;
    localparam int unsigned RC_BIT_ADAPT      = 6;
    localparam int unsigned RC_BIT_RXCAL      = 1;
    localparam int unsigned RC_BIT_TXCAL      = 5;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REQ,
        ST_GRANT_RD,
        ST_CALEN,
        ST_RATE_RD,
        ST_RATE_WR,
        ST_CAP_RD,
        ST_CAP_WR,
        ST_REL,
        ST_POLL_RD,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        BM_IDLE,
        BM_CMD,
        BM_RDATA,
        BM_ACK
    } bm_state_e;

endpackage

// File: rtl/recal_bus_master.sv
module recal_bus_master
    import recal_seq_pkg::*;
#(
    parameter int unsigned AW = RC_AW,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic          ack_o,
    output logic [DW-1:0] rdata_o,
    output logic [AW-1:0] bus_addr_o,
    output logic          bus_wr_o,
    output logic          bus_rd_o,
    output logic [DW-1:0] bus_wdata_o,
    input  logic          bus_wait_i,
    input  logic [DW-1:0] bus_rdata_i,
    input  logic          bus_rvalid_i
);

    bm_state_e     st_q;
    logic          we_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= BM_IDLE;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            unique case (st_q)
                BM_IDLE: begin
                    if (req_i) begin
                        st_q    <= BM_CMD;
                        we_q    <= we_i;
                        addr_q  <= addr_i;
                        wdata_q <= wdata_i;
                    end
                end
                BM_CMD: begin
                    if (!bus_wait_i) begin
                        st_q <= we_q ? BM_ACK : BM_RDATA;
                    end
                end
                BM_RDATA: begin
                    if (bus_rvalid_i) begin
                        rdata_q <= bus_rdata_i;
                        st_q    <= BM_ACK;
                    end
                end
                BM_ACK:  st_q <= BM_IDLE;
                default: st_q <= BM_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_wr_o    = (st_q == BM_CMD) && we_q;
        bus_rd_o    = (st_q == BM_CMD) && !we_q;
        bus_addr_o  = addr_q;
        bus_wdata_o = wdata_q;
        ack_o       = (st_q == BM_ACK);
        rdata_o     = rdata_q;
    end

    assert_excl_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_o && bus_rd_o))
        else $error("read and write strobes together");

    assert_hold_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr_o || bus_rd_o) && bus_wait_i) |=>
            ($stable(bus_wr_o) && $stable(bus_rd_o) && $stable(bus_addr_o) && $stable(bus_wdata_o)))
        else $error("access changed during stall");

endmodule

// File: rtl/recal_timeout.sv
module recal_timeout #(
    parameter int unsigned TOW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run_i,
    input  logic [TOW-1:0] limit_i,
    output logic           expired_o
);

    localparam logic [TOW-1:0] CNT_MAX = '1;

    logic [TOW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = (cnt_q >= limit_i);

    assert_tmo_saturate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX))
        else $error("timeout counter wrapped");

endmodule

// File: rtl/recal_rmw_merge.sv
module recal_rmw_merge #(
    parameter int unsigned DW = 32
) (
    input  logic [DW-1:0] old_i,
    input  logic [DW-1:0] mask_i,
    input  logic [DW-1:0] val_i,
    output logic [DW-1:0] new_o
);

    for (genvar b = 0; b < DW; b++) begin : g_bit
        assign new_o[b] = mask_i[b] ? val_i[b] : old_i[b];
    end

endmodule

// File: rtl/xcvr_recal_seq.sv
module xcvr_recal_seq
    import recal_seq_pkg::*;
#(
    parameter int unsigned DW  = 32,
    parameter int unsigned TOW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             tx_cal_en_i,
    input  logic             rx_cal_en_i,
    input  logic             rate_kept_i,
    input  logic             tx_busy_oe_i,
    input  logic             rx_busy_oe_i,
    input  logic [TOW-1:0]   tmo_limit_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic [RC_AW-1:0] bus_addr_o,
    output logic             bus_wr_o,
    output logic             bus_rd_o,
    output logic [DW-1:0]    bus_wdata_o,
    input  logic             bus_wait_i,
    input  logic [DW-1:0]    bus_rdata_i,
    input  logic             bus_rvalid_i
);

    seq_state_e state_q, state_d;

    logic tx_q, rx_q, kept_q, txoe_q, rxoe_q, err_q;

    logic             acc_req, acc_we, acc_ack;
    logic [RC_AW-1:0] acc_addr;
    logic [DW-1:0]    acc_wdata, rd_data;
    logic [DW-1:0]    mrg_mask, mrg_val, mrg_data, calen_val;
    logic             tmo_run, tmo_expired;
    logic             grant_ok, cal_idle, tmo_fire, start_ok;

    recal_bus_master #(.AW(RC_AW), .DW(DW)) u_bm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (acc_req),
        .we_i         (acc_we),
        .addr_i       (acc_addr),
        .wdata_i      (acc_wdata),
        .ack_o        (acc_ack),
        .rdata_o      (rd_data),
        .bus_addr_o   (bus_addr_o),
        .bus_wr_o     (bus_wr_o),
        .bus_rd_o     (bus_rd_o),
        .bus_wdata_o  (bus_wdata_o),
        .bus_wait_i   (bus_wait_i),
        .bus_rdata_i  (bus_rdata_i),
        .bus_rvalid_i (bus_rvalid_i)
    );

    recal_timeout #(.TOW(TOW)) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (tmo_run),
        .limit_i   (tmo_limit_i),
        .expired_o (tmo_expired)
    );

    recal_rmw_merge #(.DW(DW)) u_merge (
        .old_i  (rd_data),
        .mask_i (mrg_mask),
        .val_i  (mrg_val),
        .new_o  (mrg_data)
    );

    assign start_ok = (state_q == ST_IDLE) && start_i;
    assign grant_ok = !rd_data[RC_BIT_GRANT_PEND];
    assign cal_idle = !rd_data[RC_BIT_RXBUSY] && !rd_data[RC_BIT_TXBUSY];
    assign tmo_run  = (state_q == ST_GRANT_RD) || (state_q == ST_POLL_RD);
    assign tmo_fire = acc_ack && tmo_expired &&
                      (((state_q == ST_GRANT_RD) && !grant_ok) ||
                       ((state_q == ST_POLL_RD) && !cal_idle));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // settings latched on an accepted start, error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q   <= 1'b0;
            rx_q   <= 1'b0;
            kept_q <= 1'b0;
            txoe_q <= 1'b0;
            rxoe_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (start_ok) begin
            tx_q   <= tx_cal_en_i;
            rx_q   <= rx_cal_en_i;
            kept_q <= rate_kept_i;
            txoe_q <= tx_busy_oe_i;
            rxoe_q <= rx_busy_oe_i;
            err_q  <= 1'b0;
        end else if (tmo_fire) begin
            err_q  <= 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_d = ST_REQ;
            ST_REQ:      if (acc_ack) state_d = ST_GRANT_RD;
            ST_GRANT_RD: begin
                if (acc_ack) begin
                    if (grant_ok)         state_d = ST_CALEN;
                    else if (tmo_expired) state_d = ST_IDLE;
                end
            end
            ST_CALEN:    if (acc_ack) state_d = ST_RATE_RD;
            ST_RATE_RD:  if (acc_ack) state_d = ST_RATE_WR;
            ST_RATE_WR:  if (acc_ack) state_d = ST_CAP_RD;
            ST_CAP_RD:   if (acc_ack) state_d = ST_CAP_WR;
            ST_CAP_WR:   if (acc_ack) state_d = ST_REL;
            ST_REL:      if (acc_ack) state_d = ST_POLL_RD;
            ST_POLL_RD: begin
                if (acc_ack) begin
                    if (cal_idle)         state_d = ST_DONE;
                    else if (tmo_expired) state_d = ST_IDLE;
                end
            end
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // merge mask and value for the two read-modify-writes
    always_comb begin
        mrg_mask  = '0;
        mrg_val   = '0;
        calen_val = '0;
        calen_val[RC_BIT_RXCAL] = rx_q;
        calen_val[RC_BIT_TXCAL] = tx_q;
        if (state_q == ST_RATE_WR) begin
            mrg_mask[RC_BIT_RATE] = 1'b1;
            mrg_val[RC_BIT_RATE]  = kept_q;
        end else begin
            mrg_mask[RC_BIT_RXBOE] = 1'b1;
            mrg_mask[RC_BIT_TXBOE] = 1'b1;
            mrg_val[RC_BIT_RXBOE]  = rxoe_q;
            mrg_val[RC_BIT_TXBOE]  = txoe_q;
        end
    end

    // outputs per state
    always_comb begin
        acc_req   = 1'b0;
        acc_we    = 1'b0;
        acc_addr  = RC_ADDR_ARB;
        acc_wdata = '0;
        unique case (state_q)
            ST_REQ: begin
                acc_req   = 1'b1;
                acc_we    = 1'b1;
                acc_addr  = RC_ADDR_ARB;
                acc_wdata = DW'(RC_ARB_REQ);
            end
            ST_GRANT_RD: begin
                acc_req  = 1'b1;
                acc_addr = RC_ADDR_CAP;
            end
            ST_CALEN: begin
                acc_req   = 1'b1;
                acc_we    = 1'b1;
                acc_addr  = RC_ADDR_CALEN;
                acc_wdata = calen_val;
            end
            ST_RATE_RD: begin
                acc_req  = 1'b1;
                acc_addr = RC_ADDR_RATE;
            end
            ST_RATE_WR: begin
                acc_req   = 1'b1;
                acc_we    = 1'b1;
                acc_addr  = RC_ADDR_RATE;
                acc_wdata = mrg_data;
            end
            ST_CAP_RD: begin
                acc_req  = 1'b1;
                acc_addr = RC_ADDR_CAP;
            end
            ST_CAP_WR: begin
                acc_req   = 1'b1;
                acc_we    = 1'b1;
                acc_addr  = RC_ADDR_CAP;
                acc_wdata = mrg_data;
            end
            ST_REL: begin
                acc_req   = 1'b1;
                acc_we    = 1'b1;
                acc_addr  = RC_ADDR_ARB;
                acc_wdata = DW'(RC_ARB_REL);
            end
            ST_POLL_RD: begin
                acc_req  = 1'b1;
                acc_addr = RC_ADDR_CAP;
            end
            ST_IDLE, ST_DONE: begin
                acc_req = 1'b0;
            end
            default: acc_req = 1'b0;
        endcase
    end

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = (state_q == ST_DONE);
    assign err_o  = err_q;

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q) == ST_IDLE) |-> !(bus_wr_o || bus_rd_o))
        else $error("strobe while idle");

    assert_grant_poll_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr_o || bus_rd_o) && state_q == ST_GRANT_RD) |-> (bus_rd_o && bus_addr_o == RC_ADDR_CAP))
        else $error("access other than grant poll before grant");

    assert_adapt_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_o && bus_addr_o == RC_ADDR_CALEN) |-> !bus_wdata_o[RC_BIT_ADAPT])
        else $error("adaptation trigger bit set");

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o)
        else $error("done longer than one cycle");

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && state_q != ST_IDLE && state_q != ST_REQ) |=> (state_q != ST_REQ))
        else $error("start restarted a running sequence");

    assert_err_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!busy_o || $past(start_ok)))
        else $error("error flag outside idle");

endmodule

// File: tb/xcvr_recal_seq_tb_top.sv
`timescale 1ns/1ps
module xcvr_recal_seq_tb_top;

    localparam int DW  = 32;
    localparam int TOW = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic           tx_en = 1'b0, rx_en = 1'b0, kept = 1'b0, txoe = 1'b0, rxoe = 1'b0;
    logic [TOW-1:0] tmo_limit = 16'd1000;
    logic           busy, done, err;
    logic [9:0]     bus_addr;
    logic           bus_wr, bus_rd;
    logic [DW-1:0]  bus_wdata;
    logic           bus_wait = 1'b0;
    logic [DW-1:0]  bus_rdata = '0;
    logic           bus_rvalid = 1'b0;

    always #4 clk = ~clk;

    xcvr_recal_seq #(.DW(DW), .TOW(TOW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .tx_cal_en_i(tx_en), .rx_cal_en_i(rx_en), .rate_kept_i(kept),
        .tx_busy_oe_i(txoe), .rx_busy_oe_i(rxoe), .tmo_limit_i(tmo_limit),
        .busy_o(busy), .done_o(done), .err_o(err),
        .bus_addr_o(bus_addr), .bus_wr_o(bus_wr), .bus_rd_o(bus_rd),
        .bus_wdata_o(bus_wdata), .bus_wait_i(bus_wait),
        .bus_rdata_i(bus_rdata), .bus_rvalid_i(bus_rvalid)
    );

    typedef struct {
        logic [9:0]    addr;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;

    // register model
    logic [DW-1:0] m100 = '0, m166 = '0, m281 = '0;
    int            grant_left = 0, cal_left = 0;
    bit            grant_never = 0, cal_never = 0;
    logic [15:0]   lfsr = 16'hACE1;
    bit            rv_pend = 0;
    logic [DW-1:0] rv_data = '0;
    int            done_cnt = 0, acc_cnt = 0;
    bit            hold_pend = 0, hold_wr = 0, nw = 0;
    logic [9:0]    hold_addr = '0;
    logic [DW-1:0] hold_data = '0;

    task automatic check(input string tag, input bit ok, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, expv);
        end
    endtask

    task automatic model_write(input logic [9:0] a, input logic [DW-1:0] d);
        exp_t e;
        if (a != 10'h000) check("R4", m281[2] == 1'b0, "write before grant", {22'b0, a}, 32'h0);
        if (exp_q.size() == 0) begin
            check("R3", 1'b0, "unexpected write addr", {22'b0, a}, 32'h3ff);
        end else begin
            e = exp_q.pop_front();
            check(e.tag, a == e.addr, "write address", {22'b0, a}, {22'b0, e.addr});
            check(e.tag, d == e.data, "write data", d, e.data);
        end
        unique case (a)
            10'h000: begin
                if (d == 32'h2) begin m281[2] = 1'b1; end
                if (d == 32'h1) begin
                    m281[1] = m100[1];
                    m281[0] = m100[5];
                end
            end
            10'h100: m100 = d;
            10'h166: m166 = d;
            10'h281: m281 = d;
            default: check("R3", 1'b0, "write to unknown address", {22'b0, a}, 32'h0);
        endcase
    endtask

    task automatic model_read(input logic [9:0] a);
        if (a == 10'h166) begin
            rv_data = m166;
        end else if (a == 10'h281) begin
            if (m281[2]) begin
                if (!grant_never) begin
                    if (grant_left == 0) m281[2] = 1'b0;
                    else grant_left--;
                end
            end else if (m281[1:0] != 2'b00) begin
                if (!cal_never) begin
                    if (cal_left == 0) m281[1:0] = 2'b00;
                    else cal_left--;
                end
            end
            rv_data = m281;
        end else begin
            check("R4", 1'b0, "read of unknown address", {22'b0, a}, 32'h281);
            rv_data = '0;
        end
        rv_pend = 1'b1;
    endtask

    // slave model and monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_wait   = 1'b0;
            bus_rvalid = 1'b0;
            rv_pend    = 1'b0;
            hold_pend  = 1'b0;
        end else begin
            if (hold_pend) begin
                check("R2", (bus_wr == hold_wr) && (bus_rd == !hold_wr) && (bus_addr == hold_addr) &&
                      (!hold_wr || bus_wdata == hold_data), "access held in stall",
                      {22'b0, bus_addr}, {22'b0, hold_addr});
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            nw   = (lfsr[1:0] == 2'b00);
            bus_rvalid = 1'b0;
            if (rv_pend) begin
                bus_rvalid = 1'b1;
                bus_rdata  = rv_data;
                rv_pend    = 1'b0;
            end
            bus_wait  = nw;
            hold_pend = (bus_wr || bus_rd) && nw;
            hold_wr   = bus_wr;
            hold_addr = bus_addr;
            hold_data = bus_wdata;
            if ((bus_wr || bus_rd) && !nw) begin
                acc_cnt++;
                if (bus_wr) model_write(bus_addr, bus_wdata);
                else        model_read(bus_addr);
            end
            if (done) begin
                done_cnt++;
                check("R9", m281[1:0] == 2'b00, "done while busy bits set", {30'b0, m281[1:0]}, 32'h0);
            end
        end
    end

    task automatic push(input logic [9:0] a, input logic [DW-1:0] d, input string tag);
        exp_t e;
        e.addr = a;
        e.data = d;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    task automatic run_cal(input bit t, input bit r, input bit k, input bit toe, input bit roe,
                           input logic [DW-1:0] i166, input logic [DW-1:0] i281,
                           input int gd, input bit gnever, input int cd, input bit cnever,
                           input logic [TOW-1:0] lim, input bit poke, input bit expect_done);
        int n;
        int d0;
        int a0;
        logic [DW-1:0] calv;
        @(negedge clk);
        m166 = i166; m281 = i281;
        grant_left = gd; grant_never = gnever;
        cal_left = cd; cal_never = cnever;
        tmo_limit = lim;
        calv = '0;
        calv[1] = r;
        calv[5] = t;
        push(10'h000, 32'h2, "R3");
        if (!gnever) begin
            push(10'h100, calv, "R5");
            push(10'h166, (i166 & ~32'h80) | (DW'(k) << 7), "R6");
            push(10'h281, (i281 & ~32'h34) | (DW'(roe) << 5) | (DW'(toe) << 4), "R7");
            push(10'h000, 32'h1, "R8");
        end
        d0 = done_cnt;
        tx_en = t; rx_en = r; kept = k; txoe = toe; rxoe = roe;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R11", busy == 1'b1 && err == 1'b0, "busy set and error cleared after start",
              {30'b0, busy, err}, 32'h2);
        if (poke) begin
            repeat (8) @(negedge clk);
            tx_en = !t; rx_en = !r; kept = !k; txoe = !toe; rxoe = !roe;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check("R10", busy == 1'b1, "still running after ignored start", {31'b0, busy}, 32'h1);
        end
        n = 0;
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(expect_done ? "R9" : "R11", done_cnt - d0 == (expect_done ? 1 : 0), "done pulse count",
              DW'(done_cnt - d0), expect_done ? 32'h1 : 32'h0);
        check(expect_done ? "R9" : "R11", err == !expect_done, "error flag at end",
              {31'b0, err}, {31'b0, !expect_done});
        check(poke ? "R10" : "R8", exp_q.size() == 0, "writes outstanding", DW'(exp_q.size()), 32'h0);
        exp_q.delete();
        a0 = acc_cnt;
        repeat (30) @(negedge clk);
        check(expect_done ? "R9" : "R11", acc_cnt == a0 && !busy, "quiet after end",
              DW'(acc_cnt - a0), 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", !busy && !done && !err && !bus_wr && !bus_rd, "reset outputs",
              {27'b0, busy, done, err, bus_wr, bus_rd}, 32'h0);
        // both groups, no rate switch, both busy outputs enabled
        run_cal(1, 1, 1, 1, 1, 32'h1234_5670, 32'h0000_A548, 3, 0, 4, 0, 16'd1000, 0, 1);
        // RX only, rate switched, TX busy output only, ignored restart
        run_cal(0, 1, 0, 1, 0, 32'hFEDC_BAF9, 32'h1357_0030, 0, 0, 2, 0, 16'd1000, 1, 1);
        // grant never arrives
        run_cal(1, 0, 1, 0, 0, 32'h0, 32'h0000_0F00, 0, 1, 0, 0, 16'd50, 0, 0);
        // calibration never finishes
        run_cal(0, 1, 1, 0, 1, 32'h0000_0080, 32'h0, 1, 0, 0, 1, 16'd60, 0, 0);
        // no group selected: completes at the first poll
        run_cal(0, 0, 1, 0, 1, 32'hA5A5_A5A5, 32'hFFFF_FFF8, 2, 0, 0, 0, 16'd1000, 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule